// File: doc/BRIEF.md
# Cascaded Interrupt Controller Setup Sequencer

This block sits on a byte-wide I/O write port and configures a pair of cascaded interrupt controllers: a master and a slave. Each controller owns two adjacent addresses. A byte with bit 4 set, written to the even address, restarts that controller's setup at any time. The next three writes to the odd address then supply the vector base, the third word and the mode byte. The third word means something different for each role. On the master it is a map of the inputs that carry a slave. On the slave it is the identifier that the slave answers to during acknowledge.

A restart also forces several side effects. The interrupt mask is cleared, the pending-request register is emptied, and every request input must rise again before it can post. The lowest-priority input, the slave address, special mask mode and the status-read select return to their defaults. Once the fourth word is in, the controller reports ready, and later odd-address writes load its mask. An acknowledge datapath downstream reads the outputs; it is not part of this block.

Top module: `pic_init_pair`

## Requirements
- R1: After reset, for both controllers: ready is 0, vector base 0, third word 0, auto-EOI 0, mask 0, pending requests 0, lowest-priority input 7, slave address 7, special mask mode 0, status-read select 1 (request register). The cascade error output is 0.
- R2: The master decodes only addresses 0x20 (even) and 0x21 (odd), and the slave decodes only 0xA0 and 0xA1. A write to any other address changes no output. A write to one controller's addresses leaves the other controller unchanged.
- R3: An even-address write with data bit 4 = 1 starts setup from any state, and ready is 0 from the next cycle. An even-address write with data bit 4 = 0 is ignored.
- R4: A start write sets mask to 0 and pending requests to 0, the lowest-priority input to 7 and the slave address to 7. It also sets special mask mode to 0 and status-read select to 1.
- R5: The first odd write after a start sets the vector base output to data bits 7..3.
- R6: The second odd write after a start stores the full byte as the third-word output (a cascade map on the master, an identifier on the slave). The cascade error output is 1 exactly when the master is ready and its third word differs from 0x04.
- R7: The third odd write after a start sets auto-EOI to data bit 1. Ready is 1 from the next cycle.
- R8: While ready, an odd write loads the mask with the data byte. Odd writes before the first start are ignored.
- R9: A pending-request bit sets in the cycle after its input goes 0 to 1 and clears in the cycle after the input is 0. After a start, an input that is already high posts nothing until it has gone low and high again.
- R10: A start write in the middle of a sequence discards the partial sequence. The next odd write is then taken as the vector-base word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Write address |
| io_data | input | 8 | Write data byte |
| io_wr | input | 1 | One-cycle write strobe |
| irq_in | input | 2x8 | Request inputs, index 0 master, 1 slave |
| ready | output | 2 | Setup complete per controller |
| vec_base | output | 2x5 | Vector bits 7..3 |
| word3 | output | 2x8 | Cascade map (master) or identifier (slave) |
| auto_eoi | output | 2 | Automatic end-of-interrupt mode |
| mask | output | 2x8 | Interrupt mask |
| irr_stat | output | 2x8 | Status read: pending-request register |
| low_prio | output | 2x3 | Lowest-priority input |
| slave_addr | output | 2x3 | Slave address |
| smm | output | 2 | Special mask mode |
| rd_irr | output | 2 | Status read selects request register |
| casc_err | output | 1 | Master cascade map differs from 0x04 |

## Verification
The assertions take for granted that each write is a single-cycle strobe carrying one address. A cycle can therefore never hold both a start word and an odd-address write for the same controller. They also assume that the request inputs change only between clock edges. The stimulus is built to stay inside these limits. It drives one write per cycle on the falling edge, and it chooses addresses mostly from the four decoded ones, with a share of stray addresses. Request inputs change on the same falling edge, and for half of the even-address writes the stimulus sets data bit 4 on purpose, so that restarts land in every state of the sequence.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int NIRQ = 8;
    localparam int NCTL = 2;
    localparam int VBW  = 5;
    localparam int PW   = $clog2(NIRQ);

    localparam logic [DW-1:0] MASTER_CASC_MAP = 8'h04;
    localparam logic [PW-1:0] DFLT_LOW_PRIO   = PW'(NIRQ - 1);
    localparam logic [PW-1:0] DFLT_SLV_ADDR   = PW'(NIRQ - 1);
    localparam int            START_BIT       = 4;
    localparam int            AEOI_BIT        = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_W2,
        SQ_W3,
        SQ_W4,
        SQ_RUN
    } seq_t;

    typedef struct packed {
        logic            start;
        logic            odd_wr;
        logic [DW-1:0]   data;
    } bus_ev_t;

    typedef struct packed {
        logic [VBW-1:0]  vbase;
        logic [DW-1:0]   word3;
        logic            aeoi;
        logic [NIRQ-1:0] mask;
        logic [PW-1:0]   low_prio;
        logic [PW-1:0]   slv_addr;
        logic            smm;
        logic            rd_irr;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.vbase    = '0;
        c.word3    = '0;
        c.aeoi     = 1'b0;
        c.mask     = '0;
        c.low_prio = DFLT_LOW_PRIO;
        c.slv_addr = DFLT_SLV_ADDR;
        c.smm      = 1'b0;
        c.rd_irr   = 1'b1;
        return c;
    endfunction

    function automatic cfg_t cfg_on_start(cfg_t cur);
        cfg_t c;
        c          = cur;
        c.mask     = '0;
        c.low_prio = DFLT_LOW_PRIO;
        c.slv_addr = DFLT_SLV_ADDR;
        c.smm      = 1'b0;
        c.rd_irr   = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/pic_addr_dec.sv
module pic_addr_dec
    import pic_init_pkg::*;
#(
    parameter logic [AW-1:0] BASE = 8'h20
) (
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_data,
    input  logic          io_wr,
    output bus_ev_t       ev
);
    localparam logic [AW-1:0] EVEN_A = {BASE[AW-1:1], 1'b0};
    localparam logic [AW-1:0] ODD_A  = {BASE[AW-1:1], 1'b1};

    always_comb begin
        ev.start  = io_wr && (io_addr == EVEN_A) && io_data[START_BIT];
        ev.odd_wr = io_wr && (io_addr == ODD_A);
        ev.data   = io_data;
    end
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg
    import pic_init_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [NIRQ-1:0] irq,
    output logic [NIRQ-1:0] irr
);
    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irr    <= '0;
            prev_q <= '1;
        end else if (clr) begin
            irr    <= '0;
            prev_q <= '1;
        end else begin
            irr    <= (irr | (irq & ~prev_q)) & irq;
            prev_q <= irq;
        end
    end

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (irr == '0));
    a_r9_needs_level: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irr & ~$past(irq)) == '0));
endmodule

// File: rtl/pic_seq.sv
module pic_seq
    import pic_init_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output cfg_t    cfg,
    output logic    ready
);
    seq_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cfg <= cfg_reset();
        end else if (ev.start) begin
            st  <= SQ_W2;
            cfg <= cfg_on_start(cfg);
        end else if (ev.odd_wr) begin
            case (st)
                SQ_W2: begin
                    cfg.vbase <= ev.data[DW-1:DW-VBW];
                    st        <= SQ_W3;
                end
                SQ_W3: begin
                    cfg.word3 <= ev.data;
                    st        <= SQ_W4;
                end
                SQ_W4: begin
                    cfg.aeoi  <= ev.data[AEOI_BIT];
                    st        <= SQ_RUN;
                end
                SQ_RUN: cfg.mask <= ev.data[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    assign ready = (st == SQ_RUN);

    a_r3_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !ready);
    a_r4_start_clears_mask: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (cfg.mask == '0 && cfg.rd_irr && !cfg.smm));
    a_r7_last_word_ready: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_W4 && ev.odd_wr && !ev.start) |=> ready);
    a_r5_vbase_hold: assert property (@(posedge clk) disable iff (rst)
        !(st == SQ_W2 && ev.odd_wr) |=> $stable(cfg.vbase));
    a_r8_mask_load: assert property (@(posedge clk) disable iff (rst)
        (ready && ev.odd_wr && !ev.start) |=> (cfg.mask == $past(ev.data[NIRQ-1:0])));
    a_r8_idle_ignores: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && !ev.start) |=> $stable(cfg));
endmodule

// File: rtl/pic_init_pair.sv
module pic_init_pair
    import pic_init_pkg::*;
#(
    parameter logic [AW-1:0] MASTER_BASE = 8'h20,
    parameter logic [AW-1:0] SLAVE_BASE  = 8'hA0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [AW-1:0]              io_addr,
    input  logic [DW-1:0]              io_data,
    input  logic                       io_wr,
    input  logic [NCTL-1:0][NIRQ-1:0]  irq_in,
    output logic [NCTL-1:0]            ready,
    output logic [NCTL-1:0][VBW-1:0]   vec_base,
    output logic [NCTL-1:0][DW-1:0]    word3,
    output logic [NCTL-1:0]            auto_eoi,
    output logic [NCTL-1:0][NIRQ-1:0]  mask,
    output logic [NCTL-1:0][NIRQ-1:0]  irr_stat,
    output logic [NCTL-1:0][PW-1:0]    low_prio,
    output logic [NCTL-1:0][PW-1:0]    slave_addr,
    output logic [NCTL-1:0]            smm,
    output logic [NCTL-1:0]            rd_irr,
    output logic                       casc_err
);
    cfg_t    cfg_a [NCTL];
    bus_ev_t ev_a  [NCTL];

    for (genvar c = 0; c < NCTL; c++) begin : g_ctl
        localparam logic [AW-1:0] BASE_C = (c == 0) ? MASTER_BASE : SLAVE_BASE;

        pic_addr_dec #(.BASE(BASE_C)) u_dec (
            .io_addr (io_addr),
            .io_data (io_data),
            .io_wr   (io_wr),
            .ev      (ev_a[c])
        );

        pic_seq u_seq (
            .clk   (clk),
            .rst   (rst),
            .ev    (ev_a[c]),
            .cfg   (cfg_a[c]),
            .ready (ready[c])
        );

        pic_req_reg u_req (
            .clk (clk),
            .rst (rst),
            .clr (ev_a[c].start),
            .irq (irq_in[c]),
            .irr (irr_stat[c])
        );

        assign vec_base[c]   = cfg_a[c].vbase;
        assign word3[c]      = cfg_a[c].word3;
        assign auto_eoi[c]   = cfg_a[c].aeoi;
        assign mask[c]       = cfg_a[c].mask;
        assign low_prio[c]   = cfg_a[c].low_prio;
        assign slave_addr[c] = cfg_a[c].slv_addr;
        assign smm[c]        = cfg_a[c].smm;
        assign rd_irr[c]     = cfg_a[c].rd_irr;
    end

    assign casc_err = ready[0] && (word3[0] != MASTER_CASC_MAP);

    a_r2_stray_addr_quiet: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[AW-1:1] != MASTER_BASE[AW-1:1]
               && io_addr[AW-1:1] != SLAVE_BASE[AW-1:1])
        |=> ($stable(mask) && $stable(vec_base) && $stable(word3) && $stable(ready)));
    a_r6_casc_needs_ready: assert property (@(posedge clk) disable iff (rst)
        casc_err |-> ready[0]);
endmodule

// File: tb/pic_init_pair_tb_top.sv
module pic_init_pair_tb_top;
    import pic_init_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic [7:0] io_addr;
    logic [7:0] io_data;
    logic       io_wr;
    logic [1:0][7:0] irq_in;
    logic [1:0]      ready, auto_eoi, smm, rd_irr;
    logic [1:0][4:0] vec_base;
    logic [1:0][7:0] word3, mask, irr_stat;
    logic [1:0][2:0] low_prio, slave_addr;
    logic            casc_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pic_init_pair dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_data(io_data), .io_wr(io_wr),
        .irq_in(irq_in), .ready(ready), .vec_base(vec_base), .word3(word3),
        .auto_eoi(auto_eoi), .mask(mask), .irr_stat(irr_stat), .low_prio(low_prio),
        .slave_addr(slave_addr), .smm(smm), .rd_irr(rd_irr), .casc_err(casc_err)
    );

    // bench model of the requirements
    int         m_st [2];
    logic [4:0] m_vb [2];
    logic [7:0] m_w3 [2];
    logic       m_ae [2];
    logic [7:0] m_mk [2];
    logic [7:0] m_ir [2];
    logic [7:0] m_pv [2];

    function automatic logic [7:0] base_of(int c);
        return (c == 0) ? 8'h20 : 8'hA0;
    endfunction

    function automatic logic [7:0] next_irr(logic [7:0] ir, logic [7:0] pv, logic [7:0] q);
        return (ir | (q & ~pv)) & q;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0; m_vb[c] = '0; m_w3[c] = '0; m_ae[c] = 1'b0;
            m_mk[c] = '0; m_ir[c] = '0; m_pv[c] = 8'hFF;
        end
    endtask

    task automatic model_step(logic [7:0] a, logic [7:0] d, logic w, logic [1:0][7:0] q);
        for (int c = 0; c < 2; c++) begin
            bit st_w  = w && (a == base_of(c)) && d[4];
            bit odd_w = w && (a == (base_of(c) | 8'h01));
            if (st_w) begin
                m_st[c] = 1; m_mk[c] = '0; m_ir[c] = '0; m_pv[c] = 8'hFF;
            end else begin
                if (odd_w) begin
                    case (m_st[c])
                        1: begin m_vb[c] = d[7:3]; m_st[c] = 2; end
                        2: begin m_w3[c] = d;      m_st[c] = 3; end
                        3: begin m_ae[c] = d[1];   m_st[c] = 4; end
                        4: m_mk[c] = d;
                        default: ;
                    endcase
                end
                m_ir[c] = next_irr(m_ir[c], m_pv[c], q[c]);
                m_pv[c] = q[c];
            end
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        for (int c = 0; c < 2; c++) begin
            chk($sformatf("R3/R7 ready[%0d]", c), 32'(ready[c]), 32'(m_st[c] == 4));
            chk($sformatf("R5 vec_base[%0d]", c), 32'(vec_base[c]), 32'(m_vb[c]));
            chk($sformatf("R6 word3[%0d]", c), 32'(word3[c]), 32'(m_w3[c]));
            chk($sformatf("R7 auto_eoi[%0d]", c), 32'(auto_eoi[c]), 32'(m_ae[c]));
            chk($sformatf("R8 mask[%0d]", c), 32'(mask[c]), 32'(m_mk[c]));
            chk($sformatf("R9 irr[%0d]", c), 32'(irr_stat[c]), 32'(m_ir[c]));
            chk($sformatf("R4 defaults[%0d]", c),
                32'({low_prio[c], slave_addr[c], smm[c], rd_irr[c]}), 32'({3'd7, 3'd7, 1'b0, 1'b1}));
        end
        chk("R6 casc_err", 32'(casc_err), 32'((m_st[0] == 4) && (m_w3[0] != 8'h04)));
    endtask

    task automatic step(logic [7:0] a, logic [7:0] d, logic w);
        io_addr = a; io_data = d; io_wr = w;
        model_step(a, d, w, irq_in);
        @(negedge clk);
        io_wr = 1'b0;
        cmp_all();
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        step(a, d, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0001_5EED));
        rst = 1'b1; io_addr = '0; io_data = '0; io_wr = 1'b0; irq_in = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(ready), 32'h0);
        chk("R1 mask", 32'(mask), 32'h0);
        chk("R1 irr", 32'(irr_stat), 32'h0);
        chk("R1 low_prio", 32'(low_prio), 32'h3F);
        chk("R1 casc_err", 32'(casc_err), 32'h0);
        cmp_all();

        // R8: odd write before any start is ignored
        wr(8'h21, 8'h5A);
        chk("R8 pre-init mask", 32'(mask[0]), 32'h0);
        // master setup
        wr(8'h20, 8'h11);
        wr(8'h21, 8'h47);
        chk("R5 master vbase", 32'(vec_base[0]), 32'h08);
        wr(8'h21, 8'h04);
        chk("R7 not ready before word4", 32'(ready[0]), 32'h0);
        wr(8'h21, 8'h02);
        chk("R7 master ready", 32'(ready[0]), 32'h1);
        chk("R7 master aeoi", 32'(auto_eoi[0]), 32'h1);
        chk("R6 cascade ok", 32'(casc_err), 32'h0);
        // slave setup
        wr(8'hA0, 8'h10);
        wr(8'hA1, 8'h70);
        wr(8'hA1, 8'h02);
        chk("R6 slave id", 32'(word3[1]), 32'h02);
        wr(8'hA1, 8'h01);
        chk("R7 slave aeoi clear", 32'(auto_eoi[1]), 32'h0);
        // R8 mask load, R2 cross isolation and stray addresses
        wr(8'h21, 8'hF0);
        chk("R8 master mask", 32'(mask[0]), 32'hF0);
        wr(8'hA1, 8'h0F);
        chk("R2 master untouched", 32'(mask[0]), 32'hF0);
        wr(8'h23, 8'hFF);
        wr(8'hA2, 8'h1F);
        chk("R2 stray", 32'(mask), 32'h0FF0);
        // R3 even write without bit 4 ignored
        wr(8'h20, 8'h0B);
        chk("R3 ignored even", 32'(ready[0]), 32'h1);
        // R10 restart mid sequence, R6 cascade error
        wr(8'h20, 8'h11);
        chk("R4 mask cleared", 32'(mask[0]), 32'h0);
        wr(8'h21, 8'h80);
        wr(8'h20, 8'h13);
        wr(8'h21, 8'h88);
        chk("R10 restart vbase", 32'(vec_base[0]), 32'h11);
        wr(8'h21, 8'h05);
        wr(8'h21, 8'h00);
        chk("R6 casc mismatch", 32'(casc_err), 32'h1);
        // R9 request edge behaviour
        irq_in[0] = 8'h01;
        step(8'h00, 8'h00, 1'b0);
        chk("R9 edge posts", 32'(irr_stat[0]), 32'h01);
        wr(8'h20, 8'h11);
        chk("R9 start clears", 32'(irr_stat[0]), 32'h0);
        step(8'h00, 8'h00, 1'b0);
        chk("R9 held high no post", 32'(irr_stat[0]), 32'h0);
        irq_in[0] = 8'h00;
        step(8'h00, 8'h00, 1'b0);
        irq_in[0] = 8'h01;
        step(8'h00, 8'h00, 1'b0);
        chk("R9 fresh edge posts", 32'(irr_stat[0]), 32'h01);
        irq_in[0] = 8'h00;
        step(8'h00, 8'h00, 1'b0);
        chk("R9 low clears", 32'(irr_stat[0]), 32'h0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom % 8;
            logic [7:0] a;
            logic [7:0] d = 8'($urandom);
            logic w = 1'b1;
            case (sel)
                0: a = 8'h20;
                1, 2: a = 8'h21;
                3: a = 8'hA0;
                4, 5: a = 8'hA1;
                6: a = 8'($urandom);
                default: begin a = 8'($urandom); w = 1'b0; end
            endcase
            if ((a == 8'h20 || a == 8'hA0) && ($urandom % 2 == 0)) d[4] = 1'b1;
            if ($urandom % 4 == 0) irq_in = irq_in ^ 16'($urandom);
            step(a, d, w);
        end
        finish_run();
    end
endmodule